// File: doc/BRIEF.md
# Clock Synthesizer Serial Programmer

This block loads a 24-bit setup word into an external clock synthesizer over a two-wire line pair: a serial clock and a serial data wire. A host hands the word over on a valid/ready port. The block then plays out a fixed sequence on the two wires:

- an unlock pattern;
- a start pattern;
- the 24 data bits, each sent as a four-phase cell;
- a stop pattern.

Every phase holds the two wires steady for `PHASE_CYCLES` system clocks. After the stop pattern the wires rest high for `SETTLE_CYCLES` clocks, so the synthesizer can switch to its new frequency. Only then does the block pulse `done`.

The setup word carries a 21-bit divider value in bits 20:0 and a register select in bits 23:21. A select of 2 addresses the pixel clock register. The block does not interpret either field; it sends all 24 bits as they are.

The load port follows valid/ready rules. A word transfers on a clock edge where both `load_valid` and `load_ready` are high. `load_ready` is low for the whole time the block is busy, so the host must hold its word until `load_ready` returns. Anything offered while the block is busy is not taken.

Top module: `clksyn_prog`

## Requirements
- R1: After reset, `ser_clk` and `ser_dat` are both 1, `busy` and `done` are 0, and `load_ready` is 1.
- R2: Phases 0 to 11 after a load form the unlock pattern. In these phases `ser_dat` is 1 and `ser_clk` is 0 in even phases and 1 in odd phases.
- R3: Phases 12 to 16 form the start pattern. As (dat, clk) pairs it is (1,0), (0,0), (0,1), (0,0), (0,1).
- R4: Phases 17 to 112 carry the word least significant bit first, four phases per bit. For bit b, the four phases as (dat, clk) are (~b,1), (~b,0), (b,0), (b,1). Bit k occupies phases 17+4k to 20+4k.
- R5: Phases 113 to 115 form the stop pattern. As (dat, clk) pairs it is (1,1), (1,0), (1,1).
- R6: Each phase lasts exactly `PHASE_CYCLES` clocks. Phase 0 is on the lines in the cycle right after the accepting edge.
- R7: After the stop pattern, both lines stay at 1 for `SETTLE_CYCLES` clocks. `done` is then high for exactly one cycle, 116·`PHASE_CYCLES`+`SETTLE_CYCLES` cycles after acceptance. `busy` is high from acceptance until `done` rises, and falls in that same cycle.
- R8: `load_ready` equals the inverse of `busy`. A `load_valid` or a change of `load_word` while busy has no effect on the lines, and does not start a new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Setup word offered |
| load_ready | output | 1 | Block can accept a word |
| load_word | input | 24 | Setup word: select in 23:21, divider in 20:0 |
| busy | output | 1 | Transfer or settle in progress |
| done | output | 1 | One-cycle pulse when settle ends |
| ser_clk | output | 1 | Serial clock wire to synthesizer |
| ser_dat | output | 1 | Serial data wire to synthesizer |

## Verification
The phase index, the phase timer and the captured word together set the line levels in every cycle.

- A phase index that is off by one moves every later level by a whole phase. This shows on the lines within `PHASE_CYCLES` cycles.
- A wrong timer limit stretches or shrinks phases. The lines drift from the expected levels by the end of the first unlock phase.
- A corrupted word register shows up in the first bit cell that differs.
- A bad settle count moves the `done` pulse away from its expected cycle.

The bench compares the lines in every cycle against levels computed from the phase number.

// File: rtl/clksyn_pkg.sv
package clksyn_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_SETTLE} seq_state_t;

  typedef struct packed {
    logic dat;
    logic clk;
  } line_pair_t;

  localparam int START_PHASES = 5;
  localparam int STOP_PHASES  = 3;
  localparam int CELL_PHASES  = 4;

  function automatic int phase_total(input int word_bits, input int unlock_pairs);
    return 2 * unlock_pairs + START_PHASES + CELL_PHASES * word_bits + STOP_PHASES;
  endfunction
endpackage

// File: rtl/clksyn_timer.sv
module clksyn_timer #(
  parameter int COUNT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int CW = (COUNT > 1) ? $clog2(COUNT) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(COUNT - 1);

  logic [CW-1:0] cnt;

  assign last = run && (cnt == LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || last)   cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIMIT); // R6

  AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> cnt == '0); // R6
endmodule

// File: rtl/clksyn_cellgen.sv
module clksyn_cellgen
  import clksyn_pkg::*;
#(
  parameter int WORD_BITS    = 24,
  parameter int UNLOCK_PAIRS = 6,
  parameter int IDX_W        = 7
) (
  input  logic [IDX_W-1:0]     idx,
  input  logic [WORD_BITS-1:0] word,
  output line_pair_t           lines
);
  localparam int BIT_W = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
  localparam int START_BASE_I = 2 * UNLOCK_PAIRS;
  localparam int BIT_BASE_I   = START_BASE_I + START_PHASES;
  localparam int STOP_BASE_I  = BIT_BASE_I + CELL_PHASES * WORD_BITS;

  localparam logic [IDX_W-1:0] START_BASE = IDX_W'(START_BASE_I);
  localparam logic [IDX_W-1:0] BIT_BASE   = IDX_W'(BIT_BASE_I);
  localparam logic [IDX_W-1:0] STOP_BASE  = IDX_W'(STOP_BASE_I);

  logic [IDX_W-1:0] rel;
  logic [BIT_W-1:0] bit_num;
  logic             cur_bit;

  always_comb begin
    rel     = '0;
    bit_num = '0;
    cur_bit = 1'b0;
    lines   = '{dat: 1'b1, clk: 1'b1};
    if (idx < START_BASE) begin
      lines = '{dat: 1'b1, clk: idx[0]};
    end else if (idx < BIT_BASE) begin
      rel = idx - START_BASE;
      case (rel[2:0])
        3'd0:    lines = '{dat: 1'b1, clk: 1'b0};
        3'd1:    lines = '{dat: 1'b0, clk: 1'b0};
        3'd2:    lines = '{dat: 1'b0, clk: 1'b1};
        3'd3:    lines = '{dat: 1'b0, clk: 1'b0};
        default: lines = '{dat: 1'b0, clk: 1'b1};
      endcase
    end else if (idx < STOP_BASE) begin
      rel     = idx - BIT_BASE;
      bit_num = BIT_W'(rel >> 2);
      cur_bit = word[bit_num];
      case (rel[1:0])
        2'd0:    lines = '{dat: ~cur_bit, clk: 1'b1};
        2'd1:    lines = '{dat: ~cur_bit, clk: 1'b0};
        2'd2:    lines = '{dat:  cur_bit, clk: 1'b0};
        default: lines = '{dat:  cur_bit, clk: 1'b1};
      endcase
    end else begin
      rel   = idx - STOP_BASE;
      lines = '{dat: 1'b1, clk: (rel[1:0] != 2'd1)};
    end
  end
endmodule

// File: rtl/clksyn_prog.sv
module clksyn_prog
  import clksyn_pkg::*;
#(
  parameter int WORD_BITS     = 24,
  parameter int UNLOCK_PAIRS  = 6,
  parameter int PHASE_CYCLES  = 8,
  parameter int SETTLE_CYCLES = 12_500_000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_valid,
  output logic                 load_ready,
  input  logic [WORD_BITS-1:0] load_word,
  output logic                 busy,
  output logic                 done,
  output logic                 ser_clk,
  output logic                 ser_dat
);
  localparam int TOTAL = phase_total(WORD_BITS, UNLOCK_PAIRS);
  localparam int IDX_W = $clog2(TOTAL);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);

  seq_state_t           state;
  logic [IDX_W-1:0]     idx;
  logic [WORD_BITS-1:0] word_q;
  logic                 phase_last;
  logic                 settle_last;
  logic                 accept;
  line_pair_t           cell_lines;

  assign busy       = (state != ST_IDLE);
  assign load_ready = ~busy;
  assign accept     = load_valid && load_ready;

  clksyn_timer #(.COUNT(PHASE_CYCLES)) u_phase_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state == ST_SEND),
    .last  (phase_last)
  );

  clksyn_timer #(.COUNT(SETTLE_CYCLES)) u_settle_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state == ST_SETTLE),
    .last  (settle_last)
  );

  clksyn_cellgen #(
    .WORD_BITS    (WORD_BITS),
    .UNLOCK_PAIRS (UNLOCK_PAIRS),
    .IDX_W        (IDX_W)
  ) u_cellgen (
    .idx   (idx),
    .word  (word_q),
    .lines (cell_lines)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      idx    <= '0;
      word_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            word_q <= load_word;
            idx    <= '0;
            state  <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (phase_last) begin
            if (idx == LAST_IDX) state <= ST_SETTLE;
            else                 idx   <= idx + 1'b1;
          end
        end
        ST_SETTLE: begin
          if (settle_last) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (state == ST_SEND) begin
      ser_clk = cell_lines.clk;
      ser_dat = cell_lines.dat;
    end else begin
      ser_clk = 1'b1;
      ser_dat = 1'b1;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy)); // R7

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(word_q)); // R8

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST_IDX); // R6

  AST_PHASE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEND) && $past(state == ST_SEND) && !$past(phase_last)
      |-> $stable(idx) && $stable(ser_clk) && $stable(ser_dat)); // R6

  AST_SETTLE_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SETTLE) |-> ser_clk && ser_dat); // R7
endmodule

// File: tb/clksyn_prog_test.sv
module clksyn_prog_test;
  localparam int P = 3;
  localparam int S = 5;
  localparam int NPH = 116;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_valid = 1'b0;
  logic [23:0] load_word = '0;
  logic        load_ready, busy, done, ser_clk, ser_dat;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  clksyn_prog #(
    .WORD_BITS(24), .UNLOCK_PAIRS(6), .PHASE_CYCLES(P), .SETTLE_CYCLES(S)
  ) uut (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_ready(load_ready),
    .load_word(load_word), .busy(busy), .done(done),
    .ser_clk(ser_clk), .ser_dat(ser_dat)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected {dat, clk} for phase ph of word w
  function automatic logic [1:0] exp_lines(input int ph, input logic [23:0] w);
    int r;
    logic b;
    if (ph < 12) return {1'b1, 1'(ph % 2)};
    if (ph < 17) begin
      r = ph - 12;
      case (r)
        0: return 2'b10;
        1: return 2'b00;
        2: return 2'b01;
        3: return 2'b00;
        default: return 2'b01;
      endcase
    end
    if (ph < 113) begin
      r = ph - 17;
      b = w[r / 4];
      case (r % 4)
        0: return {~b, 1'b1};
        1: return {~b, 1'b0};
        2: return {b, 1'b0};
        default: return {b, 1'b1};
      endcase
    end
    if (ph == 114) return 2'b10;
    return 2'b11;
  endfunction

  function automatic string seg_req(input int ph);
    if (ph < 12)  return "R2";
    if (ph < 17)  return "R3";
    if (ph < 113) return "R4";
    return "R5";
  endfunction

  task automatic run_word(input logic [23:0] w);
    int busy_len;
    @(negedge clk);
    check("R8 ready before load", int'(load_ready), 1);
    load_valid = 1'b1;
    load_word  = w;
    @(posedge clk);
    busy_len = 0;
    for (int n = 0; n <= NPH * P + S; n++) begin
      @(negedge clk);
      if (n == 0) begin
        load_word  = ~w;   // offered while busy: must be ignored (R8)
        load_valid = 1'b1;
      end
      if (n == NPH * P) load_valid = 1'b0;
      if (n < NPH * P) begin
        check({seg_req(n), " R6 lines"}, int'({ser_dat, ser_clk}),
              int'(exp_lines(n / P, w)));
      end else if (n < NPH * P + S) begin
        check("R7 settle lines", int'({ser_dat, ser_clk}), 3);
      end
      if (n < NPH * P + S) begin
        check("R7 busy held", int'(busy), 1);
        check("R8 ready low", int'(load_ready), 0);
        check("R7 no early done", int'(done), 0);
        busy_len++;
      end else begin
        check("R7 done pulse", int'(done), 1);
        check("R7 busy drop", int'(busy), 0);
      end
    end
    check("R6 R7 busy length", busy_len, NPH * P + S);
    @(negedge clk);
    check("R7 done one cycle", int'(done), 0);
    check("R8 no retrigger", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ser_clk", int'(ser_clk), 1);
    check("R1 ser_dat", int'(ser_dat), 1);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 ready", int'(load_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", int'({ser_dat, ser_clk, busy}), 6);

    run_word(24'h000000);
    run_word(24'hFFFFFF);
    run_word(24'h5A5A5A);
    run_word({3'd2, 21'h12345});   // pixel clock select
    for (int k = 0; k < 24; k++) run_word(24'h1 << k);
    for (int k = 0; k < 6; k++) run_word(~(24'h1 << (4 * k)));

    repeat (4) @(negedge clk);
    check("R8 idle lines stay high", int'({ser_dat, ser_clk, busy}), 6);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule